// File: doc/BRIEF.md
# Soft-Ramp Stereo Volume Attenuator

This block attenuates a two-channel signed PCM stream in whole-decibel steps. Each channel has its own attenuation code, mute control and polarity flip. A new setting does not reach the output all at once unless software asks for that. A shared policy field picks how the working level moves toward the requested one: in a single jump, in a single jump held back until the waveform passes through zero, one decibel per sample, or one decibel per sample taken only at zero passages. A level only ever moves on a sample pulse.

Two sequencing aids surround the normal policy. After reset the working level starts at full attenuation and, if enabled, climbs one step per sample up to the programmed level. When a power-down request is raised, both channels fall to silence, one step per sample if the ramp-down option is on, and an acknowledge output tells the power controller when silence is reached. Each output sample is registered one clock after its input pulse.

Top module: `vol_ramp_atten`

## Requirements
- R1: With level 0 and no polarity flip, every output sample equals its input sample.
- R2: For level k below the maximum code 2^AW-1, the factor is g(k) = round(32768 * 10^(-k/20)) and the output is (x*g + 16384) >>> 15 (round to nearest, arithmetic shift), saturated to the signed DW-bit range. The maximum code (127 by default) gives silence.
- R3: In policy 0 (immediate), the sample that follows a change of the code already uses the new level.
- R4: In policy 1 (zero-cross), a pending level is applied only on a sample that is zero or whose sign bit differs from that of the previous sample on the same channel; until then the old level stays in use.
- R5: In policies 1 and 3, a pending change that has seen no zero passage is forced on its ZC_LIMIT-th consecutive pending sample (1024 by default).
- R6: In policy 2 (soft ramp), the working level moves one code toward the target on each sample until it equals it.
- R7: In policy 3 (ramp on zero passages), the working level moves one code toward the target, and only on a sample that qualifies as a zero passage as in R4.
- R8: A set polarity flag negates the scaled sample; the most negative input then saturates to 2^(DW-1)-1.
- R9: A mute input forces the target to the maximum code; the muted flag of that channel is high only while mute is set and the working level has reached the maximum code.
- R10: Reset leaves the working levels at the maximum code. With the ramp-up option set, each channel climbs one code per sample to its target and then follows the policy field; with it clear, the first sample jumps to the target.
- R11: While power-down is requested, both targets are the maximum code; with the ramp-down option they step one code per sample, without it they jump on the next sample; the acknowledge is high while the request is set and both levels are at the maximum code.
- R12: out_vld pulses exactly one clock after each sample pulse, and the output samples hold their values between pulses.
- R13: During and straight after reset, the output samples and out_vld are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | One-clock pulse marking a new stereo sample |
| in_l | input | DW | Left input sample, signed |
| in_r | input | DW | Right input sample, signed |
| atten_l | input | AW | Left attenuation code, 1 dB per code |
| atten_r | input | AW | Right attenuation code, 1 dB per code |
| mute_l | input | 1 | Left mute request |
| mute_r | input | 1 | Right mute request |
| inv_l | input | 1 | Left polarity flip |
| inv_r | input | 1 | Right polarity flip |
| gc_mode | input | 2 | Level-change policy: 0 immediate, 1 zero-cross, 2 soft ramp, 3 ramp on zero passages |
| ramp_up_en | input | 1 | Climb gradually from silence after reset |
| ramp_dn_en | input | 1 | Fall gradually to silence on power-down request |
| pdn_req | input | 1 | Power-down request |
| out_vld | output | 1 | Output sample strobe |
| out_l | output | DW | Left output sample, signed |
| out_r | output | DW | Right output sample, signed |
| muted_l | output | 1 | Left channel is muted and silent |
| muted_r | output | 1 | Right channel is muted and silent |
| pdn_ack | output | 1 | Both channels silent under power-down request |

## Verification
The properties assume that control inputs are steady around each sample pulse and that sample pulses are isolated single-clock events, since levels, signs and the timeout counter all advance only on those pulses. The directed stimulus changes codes, policy and option bits only in clocks without a pulse and leaves an idle clock between pulses. The step-size property is gated on the ramp-up option being set, so the ramp scenarios raise that option after the boot climb is over, where it no longer alters behaviour.

// File: rtl/vol_pkg.sv
package vol_pkg;

   typedef enum logic [1:0] {
      GC_IMMEDIATE = 2'd0,
      GC_ZERO_CROSS = 2'd1,
      GC_SOFT = 2'd2,
      GC_SOFT_ZC = 2'd3
   } gc_mode_e;

   // Linear factor for an attenuation of k decibels, in unsigned fixed point
   // with frac fraction bits; the top code is silence.
   function automatic int gain_factor(input int k, input int kmax, input int frac);
      real f;
      if (k >= kmax) return 0;
      f = (2.0 ** frac) * (10.0 ** (-k / 20.0));
      return $rtoi(f + 0.5);
   endfunction

endpackage

// File: rtl/vol_gain_rom.sv
module vol_gain_rom #(
   parameter int AW   = 7,
   parameter int FRAC = 15
) (
   input  logic [AW-1:0] lvl,
   output logic [FRAC:0] gain
);
   localparam int NENT = 2 ** AW;
   localparam int MAXL = NENT - 1;

   logic [FRAC:0] tbl [NENT];

   for (genvar k = 0; k < NENT; k++) begin : g_ent
      localparam int G = vol_pkg::gain_factor(k, MAXL, FRAC);
      assign tbl[k] = (FRAC + 1)'(G);
   end

   assign gain = tbl[lvl];

endmodule

// File: rtl/vol_level_ctrl.sv
module vol_level_ctrl #(
   parameter int DW       = 24,
   parameter int AW       = 7,
   parameter int ZC_LIMIT = 1024
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_vld,
   input  logic signed [DW-1:0] samp,
   input  logic [AW-1:0]        code,
   input  logic                 mute,
   input  logic [1:0]           mode,
   input  logic                 ramp_up_en,
   input  logic                 ramp_dn_en,
   input  logic                 pdn_req,
   output logic [AW-1:0]        lvl_nxt,
   output logic [AW-1:0]        lvl_q
);
   import vol_pkg::*;

   localparam int MAXL = 2 ** AW - 1;
   localparam int CW   = $clog2(ZC_LIMIT);

   logic [AW-1:0] tgt, step_lvl;
   logic          pend, zc, tmo, gate, waiting;
   logic          boot_q, sgn_q;
   logic [CW-1:0] wait_q;
   gc_mode_e      eff;

   always_comb begin
      tgt      = (mute || pdn_req) ? AW'(MAXL) : code;
      pend     = (lvl_q != tgt);
      zc       = (samp == '0) || (samp[DW-1] != sgn_q);
      tmo      = (wait_q == CW'(ZC_LIMIT - 1));
      gate     = zc || tmo;
      step_lvl = (lvl_q < tgt) ? lvl_q + 1'b1 : lvl_q - 1'b1;
   end

   // Sequencing overrides take precedence over the software policy.
   always_comb begin
      if (pdn_req)
         eff = ramp_dn_en ? GC_SOFT : GC_IMMEDIATE;
      else if (boot_q)
         eff = ramp_up_en ? GC_SOFT : GC_IMMEDIATE;
      else
         eff = gc_mode_e'(mode);
   end

   always_comb begin
      case (eff)
         GC_IMMEDIATE:  lvl_nxt = tgt;
         GC_ZERO_CROSS: lvl_nxt = gate ? tgt : lvl_q;
         GC_SOFT:       lvl_nxt = pend ? step_lvl : lvl_q;
         GC_SOFT_ZC:    lvl_nxt = (pend && gate) ? step_lvl : lvl_q;
         default:       lvl_nxt = lvl_q;
      endcase
      waiting = ((eff == GC_ZERO_CROSS) || (eff == GC_SOFT_ZC)) && pend && !gate;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= AW'(MAXL);
         sgn_q  <= 1'b0;
         wait_q <= '0;
         boot_q <= 1'b1;
      end else if (smp_vld) begin
         lvl_q  <= lvl_nxt;
         sgn_q  <= samp[DW-1];
         wait_q <= waiting ? wait_q + 1'b1 : '0;
         if (boot_q && (lvl_nxt == tgt))
            boot_q <= 1'b0;
      end
   end

endmodule

// File: rtl/vol_scaler.sv
module vol_scaler #(
   parameter int DW    = 24,
   parameter int FRAC  = 15,
   parameter bit ROUND = 1'b1
) (
   input  logic signed [DW-1:0] samp,
   input  logic [FRAC:0]        gain,
   input  logic                 inv,
   output logic signed [DW-1:0] y
);
   localparam int PW = DW + FRAC + 2;
   localparam logic signed [PW-1:0] SMAX = PW'((64'sd1 <<< (DW - 1)) - 64'sd1);
   localparam logic signed [PW-1:0] SMIN = -SMAX - PW'(1);

   logic signed [PW-1:0] a_ext, g_ext, prod, adj, shf, sgn;

   always_comb begin
      a_ext = PW'(samp);
      g_ext = PW'($signed({1'b0, gain}));
      prod  = a_ext * g_ext;
   end

   if (ROUND) begin : g_round
      assign adj = prod + (PW'(1) <<< (FRAC - 1));
   end else begin : g_trunc
      assign adj = prod;
   end

   always_comb begin
      shf = adj >>> FRAC;
      sgn = inv ? -shf : shf;
      if (sgn > SMAX)
         y = SMAX[DW-1:0];
      else if (sgn < SMIN)
         y = SMIN[DW-1:0];
      else
         y = sgn[DW-1:0];
   end

endmodule

// File: rtl/vol_ramp_atten.sv
module vol_ramp_atten #(
   parameter int DW       = 24,
   parameter int AW       = 7,
   parameter int FRAC     = 15,
   parameter int ZC_LIMIT = 1024,
   parameter bit ROUND    = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_vld,
   input  logic signed [DW-1:0] in_l,
   input  logic signed [DW-1:0] in_r,
   input  logic [AW-1:0]        atten_l,
   input  logic [AW-1:0]        atten_r,
   input  logic                 mute_l,
   input  logic                 mute_r,
   input  logic                 inv_l,
   input  logic                 inv_r,
   input  logic [1:0]           gc_mode,
   input  logic                 ramp_up_en,
   input  logic                 ramp_dn_en,
   input  logic                 pdn_req,
   output logic                 out_vld,
   output logic signed [DW-1:0] out_l,
   output logic signed [DW-1:0] out_r,
   output logic                 muted_l,
   output logic                 muted_r,
   output logic                 pdn_ack
);
   localparam int NCH  = 2;
   localparam int MAXL = 2 ** AW - 1;

   if (DW < 8 || DW > 32) begin : g_bad_dw
      $error("vol_ramp_atten: DW out of range");
   end
   if (AW < 3 || AW > 8) begin : g_bad_aw
      $error("vol_ramp_atten: AW out of range");
   end
   if (FRAC < 8 || FRAC > 20) begin : g_bad_frac
      $error("vol_ramp_atten: FRAC out of range");
   end
   if (ZC_LIMIT < 2) begin : g_bad_zc
      $error("vol_ramp_atten: ZC_LIMIT must be at least 2");
   end

   logic signed [DW-1:0] samp_a [NCH];
   logic [AW-1:0]        code_a [NCH];
   logic                 mute_a [NCH];
   logic                 inv_a  [NCH];
   logic [AW-1:0]        lvn_a  [NCH];
   logic [AW-1:0]        lvq_a  [NCH];
   logic [FRAC:0]        gain_a [NCH];
   logic signed [DW-1:0] y_a    [NCH];
   logic signed [DW-1:0] out_q  [NCH];
   logic [AW-1:0]        lvl_l, lvl_r;

   assign samp_a[0] = in_l;
   assign samp_a[1] = in_r;
   assign code_a[0] = atten_l;
   assign code_a[1] = atten_r;
   assign mute_a[0] = mute_l;
   assign mute_a[1] = mute_r;
   assign inv_a[0]  = inv_l;
   assign inv_a[1]  = inv_r;

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      vol_level_ctrl #(
         .DW(DW), .AW(AW), .ZC_LIMIT(ZC_LIMIT)
      ) u_lvl (
         .clk       (clk),
         .rst_n     (rst_n),
         .smp_vld   (smp_vld),
         .samp      (samp_a[ch]),
         .code      (code_a[ch]),
         .mute      (mute_a[ch]),
         .mode      (gc_mode),
         .ramp_up_en(ramp_up_en),
         .ramp_dn_en(ramp_dn_en),
         .pdn_req   (pdn_req),
         .lvl_nxt   (lvn_a[ch]),
         .lvl_q     (lvq_a[ch])
      );

      vol_gain_rom #(.AW(AW), .FRAC(FRAC)) u_rom (
         .lvl (lvn_a[ch]),
         .gain(gain_a[ch])
      );

      vol_scaler #(.DW(DW), .FRAC(FRAC), .ROUND(ROUND)) u_scl (
         .samp(samp_a[ch]),
         .gain(gain_a[ch]),
         .inv (inv_a[ch]),
         .y   (y_a[ch])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            out_q[ch] <= '0;
         else if (smp_vld)
            out_q[ch] <= y_a[ch];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         out_vld <= 1'b0;
      else
         out_vld <= smp_vld;
   end

   assign out_l   = out_q[0];
   assign out_r   = out_q[1];
   assign lvl_l   = lvq_a[0];
   assign lvl_r   = lvq_a[1];
   assign muted_l = mute_l && (lvl_l == AW'(MAXL));
   assign muted_r = mute_r && (lvl_r == AW'(MAXL));
   assign pdn_ack = pdn_req && (lvl_l == AW'(MAXL)) && (lvl_r == AW'(MAXL));

endmodule

// File: rtl/vol_ramp_atten_chk.sv
module vol_ramp_atten_chk #(
   parameter int DW = 24,
   parameter int AW = 7
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 smp_vld,
   input logic [1:0]           gc_mode,
   input logic                 ramp_up_en,
   input logic                 ramp_dn_en,
   input logic                 pdn_req,
   input logic                 pdn_ack,
   input logic                 mute_l,
   input logic [AW-1:0]        atten_l,
   input logic                 out_vld,
   input logic signed [DW-1:0] out_l,
   input logic signed [DW-1:0] out_r,
   input logic                 muted_l,
   input logic [AW-1:0]        lvl_l,
   input logic [AW-1:0]        lvl_r
);
   localparam int MAXL = 2 ** AW - 1;

   a_r12_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
      smp_vld |=> out_vld);

   a_r12_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |=> (!out_vld && $stable(out_l) && $stable(out_r)));

   a_r3_immediate_level: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && gc_mode == 2'd0 && !pdn_req && !ramp_up_en)
      |=> (lvl_l == $past(mute_l ? AW'(MAXL) : atten_l)));

   a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && gc_mode[1] && ramp_up_en && (!pdn_req || ramp_dn_en))
      |=> ((lvl_l == $past(lvl_l)) ||
           ({1'b0, lvl_l} == {1'b0, $past(lvl_l)} + 1'b1) ||
           ({1'b0, $past(lvl_l)} == {1'b0, lvl_l} + 1'b1)) &&
          ((lvl_r == $past(lvl_r)) ||
           ({1'b0, lvl_r} == {1'b0, $past(lvl_r)} + 1'b1) ||
           ({1'b0, $past(lvl_r)} == {1'b0, lvl_r} + 1'b1)));

   a_r11_ack_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && pdn_ack) |=> (out_l == '0 && out_r == '0));

   a_r9_muted_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && mute_l && muted_l) |=> (out_l == '0));

   a_r9_flag_timing: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(muted_l) |-> ($past(smp_vld) || !$past(mute_l)));

endmodule

bind vol_ramp_atten vol_ramp_atten_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .smp_vld   (smp_vld),
   .gc_mode   (gc_mode),
   .ramp_up_en(ramp_up_en),
   .ramp_dn_en(ramp_dn_en),
   .pdn_req   (pdn_req),
   .pdn_ack   (pdn_ack),
   .mute_l    (mute_l),
   .atten_l   (atten_l),
   .out_vld   (out_vld),
   .out_l     (out_l),
   .out_r     (out_r),
   .muted_l   (muted_l),
   .lvl_l     (lvl_l),
   .lvl_r     (lvl_r)
);

// File: tb/vol_ramp_atten_tb.sv
module vol_ramp_atten_tb;
   localparam longint A = 4194304;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               smp_vld = 1'b0;
   logic signed [23:0] in_l = '0, in_r = '0;
   logic [6:0]         atten_l = '0, atten_r = '0;
   logic               mute_l = 1'b0, mute_r = 1'b0, inv_l = 1'b0, inv_r = 1'b0;
   logic [1:0]         gc_mode = 2'd0;
   logic               ramp_up_en = 1'b0, ramp_dn_en = 1'b0, pdn_req = 1'b0;
   logic               out_vld, muted_l, muted_r, pdn_ack;
   logic signed [23:0] out_l, out_r;

   int n_chk = 0;
   int n_fail = 0;

   vol_ramp_atten u_dut (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .in_l(in_l), .in_r(in_r),
      .atten_l(atten_l), .atten_r(atten_r), .mute_l(mute_l), .mute_r(mute_r),
      .inv_l(inv_l), .inv_r(inv_r), .gc_mode(gc_mode), .ramp_up_en(ramp_up_en),
      .ramp_dn_en(ramp_dn_en), .pdn_req(pdn_req), .out_vld(out_vld),
      .out_l(out_l), .out_r(out_r), .muted_l(muted_l), .muted_r(muted_r),
      .pdn_ack(pdn_ack)
   );

   always #2 clk = ~clk;

   function automatic longint expv(input longint x, input int k, input bit inv);
      longint g, p, r;
      if (k >= 127) g = 0;
      else g = longint'($rtoi(32768.0 * (10.0 ** (-k / 20.0)) + 0.5));
      p = x * g;
      r = (p + 16384) >>> 15;
      if (inv) r = -r;
      if (r > 8388607) r = 8388607;
      if (r < -8388608) r = -8388608;
      return r;
   endfunction

   task automatic check(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic send(input longint xl, input longint xr);
      @(negedge clk);
      smp_vld = 1'b1;
      in_l = xl[23:0];
      in_r = xr[23:0];
      @(negedge clk);
      smp_vld = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      check("R13", "out_l after reset", out_l, 0);
      check("R13", "out_r after reset", out_r, 0);
      check("R13", "out_vld after reset", out_vld, 0);
      check("R9", "muted_l after reset", muted_l, 0);
      check("R11", "pdn_ack after reset", pdn_ack, 0);
   endtask

   task automatic t_unity();
      // first sample after reset with ramp-up off: jump to level 0 (R10)
      send(1234, -1234);
      check("R10", "first sample left", out_l, 1234);
      check("R1", "unity right", out_r, -1234);
      check("R12", "out_vld pulse", out_vld, 1);
      send(-8388608, 8388607);
      check("R1", "unity min", out_l, -8388608);
      check("R1", "unity max", out_r, 8388607);
      @(negedge clk);
      check("R12", "out_vld idle", out_vld, 0);
      check("R12", "out_l held", out_l, -8388608);
   endtask

   task automatic t_gain();
      int ks[5] = '{1, 6, 20, 40, 126};
      gc_mode = 2'd0;
      foreach (ks[i]) begin
         atten_l = 7'(ks[i]);
         atten_r = 7'(ks[i] + 1);
         send(A, -3000000);
         check("R2", $sformatf("left code %0d", ks[i]), out_l, expv(A, ks[i], 0));
         check("R3", $sformatf("right code %0d", ks[i] + 1), out_r, expv(-3000000, ks[i] + 1, 0));
      end
      atten_l = 0;
      atten_r = 0;
      send(A, A);
      check("R3", "back to 0 dB", out_l, A);
   endtask

   task automatic t_invert();
      inv_l = 1'b1;
      send(-8388608, 5);
      check("R8", "invert saturates", out_l, 8388607);
      check("R8", "other channel untouched", out_r, 5);
      send(1000, -7);
      check("R8", "invert negates", out_l, -1000);
      inv_l = 1'b0;
   endtask

   task automatic t_ramp();
      gc_mode = 2'd2;
      ramp_up_en = 1'b1;
      atten_l = 5;
      for (int i = 1; i <= 6; i++) begin
         send(A, A);
         check("R6", $sformatf("ramp down step %0d", i), out_l, expv(A, (i > 5) ? 5 : i, 0));
         check("R6", "right stays", out_r, A);
      end
      atten_l = 2;
      for (int i = 1; i <= 3; i++) begin
         send(A, A);
         check("R6", $sformatf("ramp up step %0d", i), out_l, expv(A, 5 - i, 0));
      end
      ramp_up_en = 1'b0;
   endtask

   task automatic t_zc();
      gc_mode = 2'd1;
      atten_l = 10;
      send(A, A);
      check("R4", "no crossing 1", out_l, expv(A, 2, 0));
      send(A, A);
      check("R4", "no crossing 2", out_l, expv(A, 2, 0));
      send(-A, A);
      check("R4", "sign change applies", out_l, expv(-A, 10, 0));
      atten_l = 4;
      send(-100, A);
      check("R4", "same sign holds", out_l, expv(-100, 10, 0));
      send(0, A);
      check("R4", "zero sample", out_l, 0);
      send(A, A);
      check("R4", "zero applied level", out_l, expv(A, 4, 0));
   endtask

   task automatic t_zc_timeout();
      atten_l = 12;
      for (int i = 1; i <= 1024; i++) begin
         send(A, A);
         if (i == 1) check("R5", "pending sample 1", out_l, expv(A, 4, 0));
         if (i == 1023) check("R5", "pending sample 1023", out_l, expv(A, 4, 0));
         if (i == 1024) check("R5", "forced at 1024", out_l, expv(A, 12, 0));
      end
   endtask

   task automatic t_ramp_zc();
      gc_mode = 2'd3;
      ramp_up_en = 1'b1;
      atten_l = 9;
      send(A, A);
      check("R7", "no crossing", out_l, expv(A, 12, 0));
      send(-A, A);
      check("R7", "crossing step", out_l, expv(-A, 11, 0));
      send(-A, A);
      check("R7", "hold", out_l, expv(-A, 11, 0));
      send(A, A);
      check("R7", "crossing step 2", out_l, expv(A, 10, 0));
      send(0, A);
      check("R7", "zero step", out_l, 0);
      send(A, A);
      check("R7", "reached target", out_l, expv(A, 9, 0));
      ramp_up_en = 1'b0;
   endtask

   task automatic t_mute();
      gc_mode = 2'd0;
      atten_l = 0;
      send(A, A);
      mute_l = 1'b1;
      send(A, A);
      check("R9", "muted output", out_l, 0);
      check("R9", "right unmuted", out_r, A);
      check("R9", "muted_l flag", muted_l, 1);
      check("R9", "muted_r flag", muted_r, 0);
      mute_l = 1'b0;
      send(A, A);
      check("R9", "unmute restores", out_l, A);
      check("R9", "flag cleared", muted_l, 0);
      gc_mode = 2'd2;
      ramp_up_en = 1'b1;
      mute_r = 1'b1;
      send(A, A);
      check("R9", "mute ramp first step", out_r, expv(A, 1, 0));
      repeat (125) send(A, A);
      check("R9", "not yet silent", muted_r, 0);
      send(A, A);
      check("R9", "silent flag", muted_r, 1);
      check("R9", "silent output", out_r, 0);
      mute_r = 1'b0;
      ramp_up_en = 1'b0;
      gc_mode = 2'd0;
      send(A, A);
   endtask

   task automatic t_pdn();
      ramp_dn_en = 1'b1;
      pdn_req = 1'b1;
      send(A, A);
      check("R11", "ramp down step 1", out_l, expv(A, 1, 0));
      check("R11", "ramp down step 1 right", out_r, expv(A, 1, 0));
      repeat (125) send(A, A);
      check("R11", "ack low before silence", pdn_ack, 0);
      send(A, A);
      check("R11", "ack at silence", pdn_ack, 1);
      check("R11", "silent output", out_l, 0);
      pdn_req = 1'b0;
      send(A, A);
      check("R11", "release restores", out_l, A);
      ramp_dn_en = 1'b0;
      pdn_req = 1'b1;
      send(A, A);
      check("R11", "immediate silence", out_r, 0);
      check("R11", "immediate ack", pdn_ack, 1);
      pdn_req = 1'b0;
   endtask

   task automatic t_rampup();
      ramp_up_en = 1'b1;
      gc_mode = 2'd0;
      atten_l = 3;
      atten_r = 0;
      do_reset();
      send(A, A);
      check("R10", "climb starts at 126", out_l, expv(A, 126, 0));
      repeat (122) send(A, A);
      send(A, A);
      check("R10", "left reached target", out_l, expv(A, 3, 0));
      send(A, A);
      check("R10", "left holds target", out_l, expv(A, 3, 0));
      check("R10", "right still climbing", out_r, expv(A, 2, 0));
      atten_l = 20;
      send(A, A);
      check("R10", "policy after climb", out_l, expv(A, 20, 0));
   endtask

   initial begin
      t_reset();
      t_unity();
      t_gain();
      t_invert();
      t_ramp();
      t_zc();
      t_zc_timeout();
      t_ramp_zc();
      t_mute();
      t_pdn();
      t_rampup();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #400000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule